// File: doc/BRIEF.md
# Sample Pair Splitter With Alternating Negation

The block takes a single stream of two's-complement samples, one per fast clock edge, and splits it into two parallel lanes running at half the rate. Samples with an even index since reset go to lane A and samples with an odd index go to lane B. Both members of a pair are presented together. The sign of every second pair is inverted, so the lanes carry x0/x1, then -x2/-x3, then x4/x5, and so on.

A downstream stage can take timing from either of two outputs. The first is a registered half-rate square wave: it is high while the block holds an even sample, and the pair outputs change on its falling edge. The second is a one-cycle pair-valid pulse. An input-valid qualifier lets the source insert idle cycles; an idle cycle changes nothing inside the block. Negation saturates, so the most negative code becomes the most positive one instead of wrapping back to itself.

Top module: `psplit_pair`

## Requirements
- R1: While `rst_n` is low, `out_a`, `out_b`, `pair_valid` and `half_clk` are all 0, and the next accepted sample is treated as index 0 of a non-negated pair.
- R2: The even-index accepted sample of each pair appears on `out_a` and the odd-index sample appears on `out_b`; both update on the same clock edge.
- R3: The accepted pairs are numbered from 0 after reset. Pairs 0, 2, 4 and so on pass unchanged, and pairs 1, 3, 5 and so on are arithmetically negated.
- R4: `pair_valid` is high for exactly the one cycle that follows the edge at which an odd-index sample is accepted. At that same edge `out_a` and `out_b` take the new pair, and at all other edges they hold their values.
- R5: `half_clk` becomes 1 after an even-index sample is accepted and 0 after an odd-index sample is accepted. With `in_valid` held high it is therefore a square wave at half the clock rate.
- R6: An edge with `in_valid` low is ignored: `in_data` is not captured, the pair phase and the negation polarity do not advance, and all outputs hold their values.
- R7: In a negated pair, the value 0x8000 (most negative, 16-bit default) is output as 0x7FFF. Every other value v is output as -v, so 0x7FFF becomes 0x8001, 0xFFFF becomes 0x0001 and 0 stays 0.
- R8: The sample width is the parameter `DATA_W` (default 16), and `in_data`, `out_a` and `out_b` are all `DATA_W` bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sample clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies `in_data` on this edge |
| in_data | input | DATA_W | Two's-complement input sample |
| out_a | output | DATA_W | Even-index lane, sign applied |
| out_b | output | DATA_W | Odd-index lane, sign applied |
| half_clk | output | 1 | Registered half-rate timing reference |
| pair_valid | output | 1 | One-cycle pulse when a new pair is presented |

## Verification
A corrupted phase bit shows up at the ports within one accepted sample. `half_clk` takes the wrong level, and the following pair arrives one sample early with its lanes swapped. A corrupted polarity bit stays invisible until the next pair is presented, where it shows as a wrong sign on both lanes. From then on every later pair carries the wrong sign. A stall that wrongly advances state shows up one edge later as a toggled `half_clk` or a spurious `pair_valid`.

// File: rtl/psplit_pkg.sv
package psplit_pkg;

    // Sequencer state: which member of a pair is expected next, and
    // whether the pair being assembled is to be negated.
    typedef struct packed {
        logic phase;   // 0: expecting even sample, 1: holding even sample
        logic flip;    // 1: current pair is negated
    } seq_t;

    localparam int unsigned LANES = 2;

endpackage

// File: rtl/psplit_neg.sv
module psplit_neg #(
    parameter int unsigned DATA_W  = 16,
    parameter bit          SAT_NEG = 1'b1
) (
    input  logic [DATA_W-1:0] din,
    input  logic              neg,
    output logic [DATA_W-1:0] dout
);

    localparam logic [DATA_W-1:0] MIN_V = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] MAX_V = {1'b0, {(DATA_W-1){1'b1}}};

    logic [DATA_W-1:0] inv_d;

    generate
        if (SAT_NEG) begin : g_sat
            always_comb begin
                if (din == MIN_V) inv_d = MAX_V;
                else              inv_d = (~din) + 1'b1;
            end
        end else begin : g_wrap
            always_comb inv_d = (~din) + 1'b1;
        end
    endgenerate

    always_comb dout = neg ? inv_d : din;

endmodule

// File: rtl/psplit_seq.sv
module psplit_seq
    import psplit_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic phase_o,
    output logic flip_o,
    output logic pair_o
);

    seq_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        pair_o = in_valid & s_q.phase;
        if (in_valid) begin
            s_d.phase = ~s_q.phase;
            if (s_q.phase) s_d.flip = ~s_q.flip;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign phase_o = s_q.phase;
    assign flip_o  = s_q.flip;

endmodule

// File: rtl/psplit_pair.sv
module psplit_pair
    import psplit_pkg::*;
#(
    parameter int unsigned DATA_W  = 16,
    parameter bit          SAT_NEG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic [DATA_W-1:0] out_a,
    output logic [DATA_W-1:0] out_b,
    output logic              half_clk,
    output logic              pair_valid
);

    typedef struct packed {
        logic [DATA_W-1:0] hold;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic              pv;
    } dp_t;

    dp_t r_d, r_q;

    logic phase, flip, pair_now;
    logic [DATA_W-1:0] lane_in  [LANES];
    logic [DATA_W-1:0] lane_out [LANES];

    psplit_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .phase_o (phase),
        .flip_o  (flip),
        .pair_o  (pair_now)
    );

    // Lane 0 sees the stored even sample, lane 1 the arriving odd one.
    assign lane_in[0] = r_q.hold;
    assign lane_in[1] = in_data;

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            psplit_neg #(
                .DATA_W (DATA_W),
                .SAT_NEG(SAT_NEG)
            ) u_neg (
                .din (lane_in[i]),
                .neg (flip),
                .dout(lane_out[i])
            );
        end
    endgenerate

    always_comb begin
        r_d    = r_q;
        r_d.pv = pair_now;
        if (in_valid && !phase) r_d.hold = in_data;
        if (pair_now) begin
            r_d.a = lane_out[0];
            r_d.b = lane_out[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign out_a      = r_q.a;
    assign out_b      = r_q.b;
    assign pair_valid = r_q.pv;
    assign half_clk   = phase;

endmodule

// File: rtl/psplit_chk.sv
module psplit_chk #(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] out_a,
    input logic [DATA_W-1:0] out_b,
    input logic              half_clk,
    input logic              pair_valid
);

    // R4: an accepted odd sample yields a pair pulse next cycle
    a_r4_pair_follows_odd: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && half_clk) |=> pair_valid);

    // R4: no pulse without an accepted odd sample
    a_r4_no_spurious_pair: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && half_clk) |=> !pair_valid);

    // R4: lanes hold between pairs
    a_r4_lanes_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_valid |-> ($stable(out_a) && $stable(out_b)));

    // R5: each accepted sample flips the half-rate reference
    a_r5_half_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (half_clk != $past(half_clk)));

    // R6: idle edges leave the reference untouched
    a_r6_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(half_clk));

    // R5: a pair is presented only as the reference falls
    a_r5_pair_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> !half_clk);

endmodule

bind psplit_pair psplit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_a     (out_a),
    .out_b     (out_b),
    .half_clk  (half_clk),
    .pair_valid(pair_valid)
);

// File: tb/sim_psplit_pair.sv
`timescale 1ns/1ps
module sim_psplit_pair;

    localparam int W = 16;
    localparam realtime TCK = 5.0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [W-1:0] in_data = '0;
    logic [W-1:0] out_a, out_b;
    logic half_clk, pair_valid;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // model state
    bit e_phase, e_flip, e_pv;
    logic [W-1:0] e_hold, e_a, e_b;

    localparam logic [W-1:0] VEC [16] = '{
        16'h0011, 16'h0022, 16'h8000, 16'h7FFF,
        16'h1234, 16'hFEDC, 16'h0000, 16'hFFFF,
        16'h8000, 16'h7FFF, 16'h0001, 16'hFFFF,
        16'hA5A5, 16'h5A5A, 16'h8001, 16'h0100
    };

    always #(TCK/2) clk = ~clk;

    psplit_pair #(.DATA_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .out_a(out_a), .out_b(out_b), .half_clk(half_clk), .pair_valid(pair_valid)
    );

    function automatic logic [W-1:0] sneg(input logic [W-1:0] v, input bit n);
        if (!n) return v;
        if (v == 16'h8000) return 16'h7FFF;
        return 16'(-v);
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        e_phase = 0; e_flip = 0; e_pv = 0; e_hold = '0; e_a = '0; e_b = '0;
    endtask

    task automatic step(input bit v, input logic [W-1:0] d, input string tag);
        @(negedge clk);
        in_valid = v;
        in_data  = d;
        @(posedge clk);
        #1;
        e_pv = 0;
        if (v) begin
            if (!e_phase) begin
                e_hold = d; e_phase = 1;
            end else begin
                e_a = sneg(e_hold, e_flip);
                e_b = sneg(d, e_flip);
                e_pv = 1; e_flip = ~e_flip; e_phase = 0;
            end
        end
        chk("R5", {31'd0, half_clk}, {31'd0, e_phase});
        chk("R4", {31'd0, pair_valid}, {31'd0, e_pv});
        chk(tag, {16'd0, out_a}, {16'd0, e_a});
        chk(tag, {16'd0, out_b}, {16'd0, e_b});
    endtask

    initial begin
        #(TCK * 100000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1", {16'd0, out_a}, 32'd0);
        chk("R1", {16'd0, out_b}, 32'd0);
        chk("R1", {31'd0, pair_valid}, 32'd0);
        chk("R1", {31'd0, half_clk}, 32'd0);
        // R8 lane width
        chk("R8", $bits(out_a), W);
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk: R2 lane split, R3 alternating sign, R7 saturation
        for (int i = 0; i < 16; i++) step(1'b1, VEC[i], "R2 R3 R7");

        // R6 stall while holding an even sample
        step(1'b1, 16'h1234, "R2");
        step(1'b0, 16'hAAAA, "R6");
        step(1'b0, 16'h5555, "R6");
        step(1'b1, 16'h0005, "R2");
        // R6 stall between pairs, then a negated pair (R3 R7)
        step(1'b0, 16'h7777, "R6");
        step(1'b1, 16'h8000, "R3 R7");
        step(1'b1, 16'h0003, "R3 R7");

        // mid-pair reset then first pair unnegated
        step(1'b1, 16'h0100, "R2");
        @(negedge clk);
        rst_n = 1'b0; in_valid = 1'b0;
        #1;
        chk("R1", {16'd0, out_a}, 32'd0);
        chk("R1", {16'd0, out_b}, 32'd0);
        chk("R1", {31'd0, half_clk}, 32'd0);
        chk("R1", {31'd0, pair_valid}, 32'd0);
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b1, 16'h0003, "R1 R3");
        step(1'b1, 16'h0004, "R1 R3");
        step(1'b1, 16'h0006, "R3");
        step(1'b1, 16'h0007, "R3");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule